// File: doc/BRIEF.md
# Relative-Addressed Operand Register Stack

This block holds eight operand registers for a two-operand arithmetic unit and presents them as a stack. Software names a slot by its distance from the current top: ST(0) is the top, and ST(i) is i places below it. A 3-bit pointer maps a logical slot to a physical register as (top + i) mod 8. A push moves the pointer down and writes the new value. A pop moves the pointer up and marks the old top as empty.

Every binary operation takes the top as one operand and any slot as the other. The result overwrites the top. An exchange swaps any slot with the top in one cycle, so a value anywhere in the stack can be brought to the top before it is used. The arithmetic is a plain 32-bit integer add or subtract that stands in for a real floating-point datapath.

At most one command is accepted per cycle, and only while `op_valid` is high. A command that would read an empty slot, or push onto a full stack, leaves all state unchanged and raises a sticky flag.

Top module: `regstack_unit`

## Requirements
- R1: After a synchronous active-high reset, `depth` is 0, `top_value` is 0, and both `overflow` and `underflow` are 0.
- R2: When `op_valid` is high and `op_code` is 1 (push) on a stack holding fewer than 8 values, `push_data` becomes the new top and `depth` rises by one. Both changes are visible in the cycle after the command.
- R3: A push when `depth` is 8 changes no slot, no pointer and no depth. It sets `overflow`, which stays set until reset.
- R4: `op_code` 2 (pop) on a non-empty stack removes the top, exposes the former ST(1) as the top, and lowers `depth` by one.
- R5: A pop on an empty stack leaves the state unchanged and sets `underflow`, which stays set until reset.
- R6: `op_code` 3 (add) replaces the top with ST(0) + ST(`op_idx`) modulo 2^32. `depth` and every other slot are unchanged.
- R7: `op_code` 4 (subtract) replaces the top with ST(0) - ST(`op_idx`) modulo 2^32. `depth` and every other slot are unchanged.
- R8: `op_code` 5 (exchange) swaps the contents of ST(`op_idx`) and ST(0) in a single cycle. With `op_idx` 0 it changes nothing.
- R9: For add, subtract or exchange, the command is refused when `op_idx` is not below `depth` (this covers an empty stack). A refused command changes nothing and sets `underflow`.
- R10: With `op_valid` low, or with `op_code` 0, 6 or 7, the state and flags do not change.
- R11: While the stack is empty, `top_value` reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | A command is presented this cycle |
| op_code | input | 3 | 0 none, 1 push, 2 pop, 3 add, 4 subtract, 5 exchange, 6 and 7 reserved |
| op_idx | input | 3 | Logical slot i of the second operand, ST(i) |
| push_data | input | 32 | Value written by a push |
| top_value | output | 32 | Current ST(0), or 0 when empty |
| depth | output | 4 | Number of occupied slots, 0 to 8 |
| overflow | output | 1 | Sticky: a push was refused on a full stack |
| underflow | output | 1 | Sticky: a pop or operand read hit an empty slot |

## Verification
Some properties are checked on every cycle:
- the per-slot valid tags always agree in number with `depth`;
- `depth` never exceeds eight;
- both flags stay set once they are set;
- an accepted push exposes its data and adds one to the depth;
- an exchange moves each of the two values into the other's physical register;
- an arithmetic result leaves its second operand untouched;
- an empty stack reads 0.

Other behaviour can only be shown by the bench's scenarios against an independent shifting-list model:
- the order in which values reappear after exchanges and pops;
- wrap of the pointer around the eight registers;
- arithmetic results modulo 2^32;
- the rule that refused or ignored commands leave every slot intact.

// File: rtl/regstack_pkg.sv
package regstack_pkg;

    // Command codes presented on op_code.
    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_XCHG = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    // Decided action for this cycle, after the legality checks.
    typedef enum logic [2:0] {
        ACT_IDLE  = 3'd0,
        ACT_PUSH  = 3'd1,
        ACT_POP   = 3'd2,
        ACT_ARITH = 3'd3,
        ACT_SWAP  = 3'd4,
        ACT_OVF   = 3'd5,
        ACT_UDF   = 3'd6
    } act_e;

    typedef struct packed {
        act_e act;
        logic sub;
    } plan_t;

    function automatic logic is_arith(op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/regstack_alu.sv
module regstack_alu #(
    parameter int DATA_W = 32
) (
    input  logic              sub,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        if (sub) y = a - b;
        else     y = a + b;
    end
endmodule

// File: rtl/regstack_ctrl.sv
module regstack_ctrl
    import regstack_pkg::*;
(
    input  logic       op_valid,
    input  logic [2:0] op_code,
    input  logic       top_live,
    input  logic       opnd_live,
    input  logic       full,
    output plan_t      plan
);
    op_e op;
    assign op = op_e'(op_code);

    always_comb begin
        plan.act = ACT_IDLE;
        plan.sub = 1'b0;
        if (op_valid) begin
            case (op)
                OP_PUSH: plan.act = full ? ACT_OVF : ACT_PUSH;
                OP_POP:  plan.act = top_live ? ACT_POP : ACT_UDF;
                OP_ADD, OP_SUB: begin
                    plan.act = (top_live && opnd_live) ? ACT_ARITH : ACT_UDF;
                    plan.sub = (op == OP_SUB);
                end
                OP_XCHG: plan.act = (top_live && opnd_live) ? ACT_SWAP : ACT_UDF;
                default: plan.act = ACT_IDLE;
            endcase
        end
    end

    // R10: reserved codes never produce an action
    always_comb begin
        if (op_valid && (op == OP_RSV6 || op == OP_RSV7))
            p_rsv_idle_r10: assert (plan.act == ACT_IDLE);
    end

    // R9: an arithmetic command without a live operand is always refused
    always_comb begin
        if (op_valid && is_arith(op) && !opnd_live)
            p_dead_opnd_r9: assert (plan.act == ACT_UDF);
    end
endmodule

// File: rtl/regstack_ptr.sv
module regstack_ptr
    import regstack_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int PTR_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  plan_t            plan,
    output logic [PTR_W-1:0] top_q,
    output logic [CNT_W-1:0] depth_q,
    output logic             ovf_q,
    output logic             udf_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            top_q   <= '0;
            depth_q <= '0;
            ovf_q   <= 1'b0;
            udf_q   <= 1'b0;
        end else begin
            case (plan.act)
                ACT_PUSH: begin
                    top_q   <= top_q - PTR_W'(1);
                    depth_q <= depth_q + CNT_W'(1);
                end
                ACT_POP: begin
                    top_q   <= top_q + PTR_W'(1);
                    depth_q <= depth_q - CNT_W'(1);
                end
                ACT_OVF: ovf_q <= 1'b1;
                ACT_UDF: udf_q <= 1'b1;
                default: ;
            endcase
        end
    end

    p_depth_bound_r3: assert property (@(posedge clk) disable iff (rst)
        depth_q <= CNT_W'(SLOTS));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

    p_udf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        udf_q |=> udf_q);

    p_pop_depth_r4: assert property (@(posedge clk) disable iff (rst)
        plan.act == ACT_POP |=> depth_q == $past(depth_q) - CNT_W'(1));

    p_refused_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (plan.act == ACT_UDF || plan.act == ACT_OVF) |=> $stable(depth_q) && $stable(top_q));
endmodule

// File: rtl/regstack_file.sv
module regstack_file
    import regstack_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SLOTS  = 8,
    localparam int PTR_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  plan_t             plan,
    input  logic [PTR_W-1:0]  top_q,
    input  logic [PTR_W-1:0]  idx,
    input  logic [DATA_W-1:0] push_data,
    input  logic [CNT_W-1:0]  depth_q,
    output logic              top_live,
    output logic              opnd_live,
    output logic              full,
    output logic [DATA_W-1:0] top_value
);
    logic [DATA_W-1:0] mem_q [SLOTS];
    logic [SLOTS-1:0]  valid_q;
    logic [PTR_W-1:0]  pa_top, pa_opnd, pa_new;
    logic [DATA_W-1:0] alu_y;

    // Logical-to-physical mapping; PTR_W-bit arithmetic wraps mod SLOTS.
    assign pa_top  = top_q;
    assign pa_opnd = top_q + idx;
    assign pa_new  = top_q - PTR_W'(1);

    assign top_live  = valid_q[pa_top];
    assign opnd_live = valid_q[pa_opnd];
    assign full      = valid_q[pa_new];
    assign top_value = top_live ? mem_q[pa_top] : '0;

    regstack_alu #(.DATA_W(DATA_W)) u_alu (
        .sub (plan.sub),
        .a   (mem_q[pa_top]),
        .b   (mem_q[pa_opnd]),
        .y   (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SLOTS; s++) mem_q[s] <= '0;
            valid_q <= '0;
        end else begin
            case (plan.act)
                ACT_PUSH: begin
                    mem_q[pa_new]   <= push_data;
                    valid_q[pa_new] <= 1'b1;
                end
                ACT_POP:   valid_q[pa_top] <= 1'b0;
                ACT_ARITH: mem_q[pa_top] <= alu_y;
                ACT_SWAP: begin
                    if (pa_opnd != pa_top) begin
                        mem_q[pa_top]  <= mem_q[pa_opnd];
                        mem_q[pa_opnd] <= mem_q[pa_top];
                    end
                end
                default: ;
            endcase
        end
    end

    p_tags_match_depth_r2: assert property (@(posedge clk) disable iff (rst)
        CNT_W'($countones(valid_q)) == depth_q);

    p_swap_moves_r8: assert property (@(posedge clk) disable iff (rst)
        plan.act == ACT_SWAP |=>
            mem_q[$past(pa_opnd)] == $past(mem_q[pa_top]) &&
            mem_q[$past(pa_top)]  == $past(mem_q[pa_opnd]));

    p_arith_keeps_opnd_r6: assert property (@(posedge clk) disable iff (rst)
        (plan.act == ACT_ARITH && pa_opnd != pa_top) |=>
            mem_q[$past(pa_opnd)] == $past(mem_q[pa_opnd]));
endmodule

// File: rtl/regstack_unit.sv
module regstack_unit
    import regstack_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SLOTS  = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       op_valid,
    input  logic [2:0]                 op_code,
    input  logic [$clog2(SLOTS)-1:0]   op_idx,
    input  logic [DATA_W-1:0]          push_data,
    output logic [DATA_W-1:0]          top_value,
    output logic [$clog2(SLOTS+1)-1:0] depth,
    output logic                       overflow,
    output logic                       underflow
);
    localparam int PTR_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(SLOTS + 1);

    plan_t            plan;
    logic [PTR_W-1:0] top_q;
    logic             top_live, opnd_live, full;

    regstack_ctrl u_ctrl (
        .op_valid  (op_valid),
        .op_code   (op_code),
        .top_live  (top_live),
        .opnd_live (opnd_live),
        .full      (full),
        .plan      (plan)
    );

    regstack_ptr #(.SLOTS(SLOTS)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .plan    (plan),
        .top_q   (top_q),
        .depth_q (depth),
        .ovf_q   (overflow),
        .udf_q   (underflow)
    );

    regstack_file #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_file (
        .clk       (clk),
        .rst       (rst),
        .plan      (plan),
        .top_q     (top_q),
        .idx       (op_idx),
        .push_data (push_data),
        .depth_q   (depth),
        .top_live  (top_live),
        .opnd_live (opnd_live),
        .full      (full),
        .top_value (top_value)
    );

    p_empty_reads_zero_r11: assert property (@(posedge clk) disable iff (rst)
        depth == CNT_W'(0) |-> top_value == '0);

    p_push_lands_r2: assert property (@(posedge clk) disable iff (rst)
        plan.act == ACT_PUSH |=> top_value == $past(push_data) &&
                                 depth == $past(depth) + CNT_W'(1));
endmodule

// File: tb/regstack_unit_test.sv
module regstack_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [2:0]  op_idx;
    logic [31:0] push_data;
    logic [31:0] top_value;
    logic [3:0]  depth;
    logic        overflow, underflow;

    int checks = 0;
    int errors = 0;

    // Independent model: lst[0] is the top, entries shift on push and pop.
    logic [31:0] lst [8];
    int          md;
    bit          movf, mudf;

    always #2 clk = ~clk;

    regstack_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_idx(op_idx), .push_data(push_data), .top_value(top_value),
        .depth(depth), .overflow(overflow), .underflow(underflow)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mdl_top();
        return (md == 0) ? 32'd0 : lst[0];
    endfunction

    task automatic mdl_apply(bit v, logic [2:0] c, int i, logic [31:0] d);
        logic [31:0] t;
        if (!v) return;
        case (c)
            3'd1: if (md == 8) movf = 1; else begin
                for (int k = 7; k > 0; k--) lst[k] = lst[k-1];
                lst[0] = d; md++;
            end
            3'd2: if (md == 0) mudf = 1; else begin
                for (int k = 0; k < 7; k++) lst[k] = lst[k+1];
                md--;
            end
            3'd3, 3'd4, 3'd5: if (i >= md) mudf = 1; else begin
                if (c == 3'd3)      lst[0] = lst[0] + lst[i];
                else if (c == 3'd4) lst[0] = lst[0] - lst[i];
                else begin t = lst[0]; lst[0] = lst[i]; lst[i] = t; end
            end
            default: ;
        endcase
    endtask

    task automatic check_all(string tag);
        check({tag, " top"},   top_value, mdl_top());
        check({tag, " depth"}, {28'd0, depth}, md);
        check({tag, " ovf"},   {31'd0, overflow}, {31'd0, movf});
        check({tag, " udf"},   {31'd0, underflow}, {31'd0, mudf});
    endtask

    task automatic do_op(string tag, bit v, logic [2:0] c, int i, logic [31:0] d);
        @(negedge clk);
        op_valid = v; op_code = c; op_idx = 3'(i); push_data = d;
        @(negedge clk);
        op_valid = 1'b0;
        mdl_apply(v, c, i, d);
        check_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        md = 0; movf = 0; mudf = 0;
        for (int k = 0; k < 8; k++) lst[k] = '0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_code = '0; op_idx = '0; push_data = '0;
        void'($urandom(32'h5EED_1234));
        do_reset();
        check_all("R1 reset");
        check("R11 empty top", top_value, 32'd0);

        for (int k = 0; k < 8; k++) do_op("R2 push", 1, 3'd1, 0, 32'h100 + k);
        do_op("R3 push full", 1, 3'd1, 0, 32'hDEAD);
        do_op("R6 add", 1, 3'd3, 3, 0);
        do_op("R7 sub", 1, 3'd4, 7, 0);
        do_op("R8 xchg", 1, 3'd5, 5, 0);
        do_op("R8 xchg self", 1, 3'd5, 0, 0);
        do_op("R10 valid low", 0, 3'd2, 0, 0);
        do_op("R10 code6", 1, 3'd6, 0, 0);
        do_op("R10 code7", 1, 3'd7, 0, 0);
        for (int k = 0; k < 8; k++) do_op("R4 pop", 1, 3'd2, 0, 0);
        do_op("R5 pop empty", 1, 3'd2, 0, 0);
        check("R11 empty after pops", top_value, 32'd0);

        do_reset();
        do_op("R9 add empty", 1, 3'd3, 0, 0);
        do_reset();
        do_op("R2 push", 1, 3'd1, 0, 32'hFFFF_FFFF);
        do_op("R2 push", 1, 3'd1, 0, 32'h2);
        do_op("R6 add wrap", 1, 3'd3, 1, 0);
        do_op("R9 add beyond", 1, 3'd3, 2, 0);
        do_op("R9 xchg beyond", 1, 3'd5, 4, 0);
        do_op("R7 sub", 1, 3'd4, 1, 0);
        do_op("R4 pop", 1, 3'd2, 0, 0);

        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [2:0] c;
            if (n % 250 == 0) do_reset();
            r = int'($urandom_range(0, 99));
            if (r < 35)      c = 3'd1;
            else if (r < 55) c = 3'd2;
            else if (r < 67) c = 3'd3;
            else if (r < 77) c = 3'd4;
            else if (r < 92) c = 3'd5;
            else             c = 3'($urandom_range(0, 7));
            do_op("R2..R10 random", ($urandom_range(0, 9) != 0), c,
                  int'($urandom_range(0, 7)), $urandom());
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule